// File: doc/BRIEF.md
# Ten-Source Interrupt Combiner

This block gathers ten board-level interrupt lines into a single active-low request for a processor pin that reacts to falling edges. Every line passes through a two-flop synchronizer and then through a trigger detector. Software picks the trigger type for each line: no trigger, falling edge, rising edge, either edge, low level or high level. Each detected event sets a sticky pending bit. The request output is asserted, meaning driven low, while any pending source is also enabled in the mask register.

Software reaches the block over a plain 16-bit register bus. The bus has a select, a write strobe, a word address and a read path that answers in the same cycle. Five registers are mapped: the pending status, the mask, two trigger-type registers that hold five 3-bit fields each, and a read-only identification word. To clear a pending bit, software writes a 0 to it. Writing all ones to the mask and then writing the working mask back releases the output and drives it low again. This gives the processor a new falling edge for any source that is still pending.

Top module: `irq_combiner`

## Requirements
- R1: After reset the status register reads 0x0000, the mask reads 0xFFFF, both trigger registers read 0x0000 and `irq_n` is 1.
- R2: The trigger register at address 2 holds the fields for sources 0 to 4, with source n in bits 3n+2:3n. The register at address 3 holds sources 5 to 9, with source n in bits 3(n-5)+2:3(n-5). Bit 15 of both registers reads 0 and ignores writes.
- R3: Trigger code 1 (falling edge) sets a source's pending bit at status address 0, bit n. The bit is set on the third rising clock edge after the input falls, and not on the second. A rising input does not set it.
- R4: Code 2 (rising edge) latches only when the input rises. Code 3 (either edge) latches on both transitions.
- R5: Code 4 (low level) and code 5 (high level) set the pending bit on every cycle the level holds. While the level is active, a clear does not stick. Once the level has ended, a clear does stick.
- R6: Codes 0, 6 and 7 never set the pending bit, whatever the input does.
- R7: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: If a detected event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R9: Mask bit n (address 1) set to 1 disables source n and 0 enables it. A masked source still latches into status. `irq_n` is 0 exactly when some source is both pending and enabled.
- R10: Writing 0xFFFF to the mask drives `irq_n` to 1 from the next cycle. Writing the working mask back then drives it to 0 again while an enabled source is still pending.
- R11: Address 4 returns the board number in bits 15:8 and the revision in bits 7:0. Writes to it have no effect.
- R12: Status bits 15:10 always read 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Raw interrupt source lines, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read, while selected |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| irq_n | output | 1 | Combined active-low interrupt request |

## Verification
A change on a source line reaches the status register on the third rising clock edge. Two of those edges go to the synchronizer and one to the pending flop. The bench changes inputs on a falling edge, steps exactly three falling edges and only then reads status. It also reads once after two steps to confirm that the bit has not been set early. Register writes and the output changes that follow them take one clock edge, so each write task returns on the next falling edge and the bench samples `irq_n` there. The same-cycle collision case starts the clearing write after two steps so that it lands on the very edge that captures the event. Reads are combinational and are sampled 1 ns after the address is applied, with no clock edge in between.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
    localparam logic [2:0] TRIG_NONE   = 3'd0;
    localparam logic [2:0] TRIG_FALL   = 3'd1;
    localparam logic [2:0] TRIG_RISE   = 3'd2;
    localparam logic [2:0] TRIG_BOTH   = 3'd3;
    localparam logic [2:0] TRIG_LVL_LO = 3'd4;
    localparam logic [2:0] TRIG_LVL_HI = 3'd5;

    localparam int TRIG_W = 3;

    localparam logic [2:0] REG_STATUS  = 3'd0;
    localparam logic [2:0] REG_MASK    = 3'd1;
    localparam logic [2:0] REG_TRIG_LO = 3'd2;
    localparam logic [2:0] REG_TRIG_HI = 3'd3;
    localparam logic [2:0] REG_IDENT   = 3'd4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
    import irq_comb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic [TRIG_W-1:0] trig_i,
    output logic              evt_o
);
    logic lvl;
    logic prev_d, prev_q;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_i),
        .dout (lvl)
    );

    always_comb begin
        prev_d = lvl;
        unique case (trig_i)
            TRIG_FALL:   evt_o = prev_q & ~lvl;
            TRIG_RISE:   evt_o = ~prev_q & lvl;
            TRIG_BOTH:   evt_o = prev_q ^ lvl;
            TRIG_LVL_LO: evt_o = ~lvl;
            TRIG_LVL_HI: evt_o = lvl;
            default:     evt_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R6: an unused code never produces an event
    p_no_trigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == TRIG_NONE || trig_i > TRIG_LVL_HI) |-> !evt_o)
        else $error("p_no_trigger_r6");
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int          NUM_SRC     = 10,
    parameter int          DATA_W      = 16,
    parameter int          ADDR_W      = 3,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  BOARD_NUM   = 8'h03,
    parameter logic [7:0]  BOARD_REV   = 8'h21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);
    localparam int PER_REG = DATA_W / TRIG_W;
    localparam int LO_W    = PER_REG * TRIG_W;
    localparam int ALL_W   = NUM_SRC * TRIG_W;
    localparam int HI_W    = ALL_W - LO_W;
    localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({BOARD_NUM, BOARD_REV});

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [DATA_W-1:0]  mask;
        logic [ALL_W-1:0]   trig;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_SRC-1:0] evt;
    logic wr_stat, wr_mask, wr_lo, wr_hi;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            irq_src_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .raw_i (src_i[gi]),
                .trig_i(st_q.trig[TRIG_W*gi +: TRIG_W]),
                .evt_o (evt[gi])
            );
        end
    endgenerate

    always_comb begin
        wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_STATUS));
        wr_mask = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_MASK));
        wr_lo   = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_TRIG_LO));
        wr_hi   = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_TRIG_HI));

        st_d = st_q;
        if (wr_stat) st_d.pend = (st_q.pend & bus_wdata[NUM_SRC-1:0]) | evt;
        else         st_d.pend = st_q.pend | evt;
        if (wr_mask) st_d.mask = bus_wdata;
        if (wr_lo)   st_d.trig[LO_W-1:0] = bus_wdata[LO_W-1:0];
        if (wr_hi)   st_d.trig[ALL_W-1:LO_W] = bus_wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
            st_q.trig <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(REG_STATUS):  bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, st_q.pend};
                ADDR_W'(REG_MASK):    bus_rdata = st_q.mask;
                ADDR_W'(REG_TRIG_LO): bus_rdata = {{(DATA_W-LO_W){1'b0}}, st_q.trig[LO_W-1:0]};
                ADDR_W'(REG_TRIG_HI): bus_rdata = {{(DATA_W-HI_W){1'b0}}, st_q.trig[ALL_W-1:LO_W]};
                ADDR_W'(REG_IDENT):   bus_rdata = ID_WORD;
                default:              bus_rdata = '0;
            endcase
        end
    end

    assign irq_n = ~|(st_q.pend & ~st_q.mask[NUM_SRC-1:0]);

    // R7: bits written as 0 with no event that cycle end up cleared
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((st_q.pend & ~$past(bus_wdata[NUM_SRC-1:0]) & ~$past(evt)) == '0))
        else $error("p_clear_zero_r7");

    // R8: every detected event is held in status on the following cycle
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q.pend & $past(evt)) == $past(evt)))
        else $error("p_event_wins_r8");

    // R10: masking everything releases the request one cycle later
    p_mask_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && bus_wdata == '1) |=> irq_n)
        else $error("p_mask_release_r10");

    // R9: request can only be active while some enabled source is pending
    p_req_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (st_q.pend != '0))
        else $error("p_req_needs_pend_r9");
endmodule

// File: tb/test_irq_combiner.sv
module test_irq_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_i = '1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    irq_combiner i_irq_combiner (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); chk("R1 status", v, 16'h0000);
        rd(3'd1, v); chk("R1 mask", v, 16'hFFFF);
        rd(3'd2, v); chk("R1 trig lo", v, 16'h0000);
        rd(3'd3, v); chk("R1 trig hi", v, 16'h0000);
        chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_fields;
        logic [15:0] v;
        wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R2 lo bit15", v, 16'h7FFF);
        wr(3'd3, 16'hFFFF); rd(3'd3, v); chk("R2 hi bit15", v, 16'h7FFF);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
        // source 7 rising edge: field at hi bits 8:6
        wr(3'd3, 16'h0080);
        src_i[7] = 1'b0; step(3);
        src_i[7] = 1'b1; step(3);
        rd(3'd0, v); chk("R2 source 7 field", v, 16'h0080);
        wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
    endtask

    task automatic t_edges;
        logic [15:0] v;
        wr(3'd2, 16'h00D1); // src0 fall, src1 rise, src2 both
        src_i[2:0] = 3'b000;
        step(2); rd(3'd0, v); chk("R3 not before third edge", v, 16'h0000);
        step(1); rd(3'd0, v); chk("R3 R4 falling", v, 16'h0005);
        wr(3'd0, 16'h0000);
        src_i[2:0] = 3'b111; step(3);
        rd(3'd0, v); chk("R4 rising", v, 16'h0006);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R7 clear all", v, 16'h0000);
        wr(3'd2, 16'h0000);
    endtask

    task automatic t_levels;
        logic [15:0] v;
        wr(3'd3, 16'h0005); // src5 high level, input already high
        step(1);
        rd(3'd0, v); chk("R5 level high latch", v, 16'h0020);
        wr(3'd0, 16'hFFDF);
        rd(3'd0, v); chk("R5 clear while held", v, 16'h0020);
        src_i[5] = 1'b0; step(3);
        wr(3'd0, 16'hFFDF);
        rd(3'd0, v); chk("R5 clear after level ends", v, 16'h0000);
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h0800); // src3 low level
        src_i[3] = 1'b0; step(3);
        rd(3'd0, v); chk("R5 level low latch", v, 16'h0008);
        src_i[3] = 1'b1; step(3);
        wr(3'd0, 16'hFFF7);
        rd(3'd0, v); chk("R5 low clear sticks", v, 16'h0000);
        wr(3'd2, 16'h0000);
        src_i[5] = 1'b1; step(3);
    endtask

    task automatic t_none;
        logic [15:0] v;
        wr(3'd3, 16'h0030); // src6 code 6, src4 code 0
        src_i[4] = 1'b0; src_i[6] = 1'b0; step(4);
        src_i[4] = 1'b1; src_i[6] = 1'b1; step(4);
        rd(3'd0, v); chk("R6 no trigger", v, 16'h0000);
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_clear;
        logic [15:0] v;
        wr(3'd2, 16'h00D1);
        src_i[0] = 1'b0; src_i[2] = 1'b0; step(3);
        wr(3'd0, 16'hFFFE);
        rd(3'd0, v); chk("R7 clear one bit", v, 16'h0004);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk("R12 high status bits", v, 16'h0004);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        src_i[0] = 1'b1; src_i[2] = 1'b1; step(3);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        wr(3'd2, 16'h0010); // src1 rising
        src_i[1] = 1'b0; step(3);
        src_i[1] = 1'b1; step(2);
        wr(3'd0, 16'h0000); // lands on the capturing edge
        rd(3'd0, v); chk("R8 event beats clear", v, 16'h0002);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R8 later clear", v, 16'h0000);
        wr(3'd2, 16'h0000);
    endtask

    task automatic t_mask;
        logic [15:0] v;
        wr(3'd2, 16'h0001);
        src_i[0] = 1'b0; step(3);
        rd(3'd0, v); chk("R9 masked still latches", v, 16'h0001);
        chk("R9 masked irq_n", {15'd0, irq_n}, 16'h0001);
        wr(3'd1, 16'hFFFE);
        chk("R9 enabled irq_n", {15'd0, irq_n}, 16'h0000);
        rd(3'd1, v); chk("R9 mask readback", v, 16'hFFFE);
        wr(3'd1, 16'hFFFF);
        chk("R10 release", {15'd0, irq_n}, 16'h0001);
        wr(3'd1, 16'hFFFE);
        chk("R10 reassert", {15'd0, irq_n}, 16'h0000);
        wr(3'd0, 16'hFFFE);
        chk("R9 cleared irq_n", {15'd0, irq_n}, 16'h0001);
        src_i[0] = 1'b1; step(3);
        wr(3'd2, 16'h0000);
    endtask

    task automatic t_ident;
        logic [15:0] v;
        rd(3'd4, v); chk("R11 ident", v, 16'h0321);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R11 ident write ignored", v, 16'h0321);
        rd(3'd7, v); chk("R12 unmapped", v, 16'h0000);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        t_reset();
        t_fields();
        t_edges();
        t_levels();
        t_none();
        t_clear();
        t_collide();
        t_mask();
        t_ident();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule